// File: doc/BRIEF.md
# Soft-Reset and Clock-Gate Sequencer

This block brings a peripheral out of soft reset and opens its clock gate, using only that peripheral's control register. It reaches the register through a simple word-wide port: it issues a read, takes the data one cycle later, and writes back a word in which only one bit differs. Every step of the procedure is such a read-modify-write, usually followed by repeated reads until one status bit shows the expected value.

A start pulse launches a run, and a mode input picks between two variants. In enable-only mode the sequencer releases reset and ungates the clock. In full-reset mode it also pulses the soft-reset bit and waits for the peripheral to acknowledge entry into reset. Each wait gives up after a bounded number of reads. The attempt then fails, and the whole procedure starts again from its first step, up to a bounded number of attempts. The result comes out as a one-cycle success or failure pulse, with a count of the attempts used.

Top module: `rstgate_seq`

## Requirements
- R1: After reset, busy, done and error are 0, attempts is 0, and the block issues no register read or write until a start is accepted.
- R2: The register port reads by raising reg_rd for one cycle, with reg_rdata valid in the following cycle and held until the next read. It writes by raising reg_wr with reg_wdata. A read and a write never share a cycle. Each written word differs from the most recently read word in at most one bit, and that bit is bit 31 (soft reset) or bit 30 (clock gate).
- R3: With start_full = 0 (enable-only), one attempt writes bit 31 cleared, then polls until bit 31 reads 0, then writes bit 30 cleared, then polls until bit 30 reads 0. Done is raised only after that final poll sees bit 30 at 0.
- R4: With start_full = 1 (full reset), one attempt follows the first clear of bit 30 with four more steps: it writes bit 31 set and polls until bit 30 reads 1; it writes bit 31 cleared and polls until bit 31 reads 0; it writes bit 30 cleared; and it runs the same final poll on bit 30.
- R5: A poll that has made POLL_LIMIT reads without seeing the expected value ends the attempt as failed. A match on the last permitted read still counts as success.
- R6: A failed attempt restarts the procedure at its first step and increments attempts. When attempt number MAX_TRIES fails, the block raises error and stops.
- R7: Done and error are one-cycle pulses that never occur together. Busy is 0 in the pulse cycle. Attempts holds its final value until the next start is accepted.
- R8: A start seen while busy is 1 is ignored, together with its mode value.
- R9: A start presented in the same cycle as a done or error pulse is accepted and begins a new run.
- R10: All bits other than 31 and 30 are written back exactly as read, so the peripheral's other control bits survive the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted when idle |
| start_full | input | 1 | Mode sampled with start: 1 full reset, 0 enable-only |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle pulse after the last attempt fails |
| attempts | output | $clog2(MAX_TRIES+1) | Attempts used by the current or most recent run |
| reg_rd | output | 1 | Read request to the control register |
| reg_wr | output | 1 | Write strobe to the control register |
| reg_wdata | output | DATA_W | Word to write |
| reg_rdata | input | DATA_W | Read data, valid the cycle after reg_rd |

## Verification
The completion pulse and the acceptance of a new start can fall in the same cycle. The bench waits for done at a falling edge and raises start with the opposite mode right away, so the next rising edge sees both. It then expects two scoreboard entries: the first run's result, and a complete full-reset run whose write history begins from the register as the first run left it. The other overlap is a start arriving mid-run. That run must still finish in the mode captured at its own launch.

// File: rtl/rstgate_pkg.sv
package rstgate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RMW_RD,
    ST_RMW_WR,
    ST_POLL_RD,
    ST_POLL_CHK
  } seq_state_t;

  typedef enum logic [2:0] {
    PH_RELEASE_A,
    PH_UNGATE_A,
    PH_ENTER,
    PH_RELEASE_B,
    PH_UNGATE_B,
    PH_SETTLE
  } phase_t;

  typedef struct packed {
    logic rmw;          // phase performs a read-modify-write
    logic rmw_val;      // value written to the chosen bit
    logic rmw_on_gate;  // 1: clock-gate bit, 0: soft-reset bit
    logic poll;         // phase waits on a status bit
    logic poll_on_gate; // 1: watch clock-gate bit, 0: soft-reset bit
    logic poll_val;     // value that ends the wait
  } phase_op_t;

  function automatic phase_op_t phase_op(input phase_t ph);
    phase_op_t o;
    o = '0;
    case (ph)
      PH_RELEASE_A, PH_RELEASE_B: begin
        o.rmw = 1'b1; o.rmw_val = 1'b0; o.rmw_on_gate = 1'b0;
        o.poll = 1'b1; o.poll_on_gate = 1'b0; o.poll_val = 1'b0;
      end
      PH_UNGATE_A, PH_UNGATE_B: begin
        o.rmw = 1'b1; o.rmw_val = 1'b0; o.rmw_on_gate = 1'b1;
      end
      PH_ENTER: begin
        o.rmw = 1'b1; o.rmw_val = 1'b1; o.rmw_on_gate = 1'b0;
        o.poll = 1'b1; o.poll_on_gate = 1'b1; o.poll_val = 1'b1;
      end
      PH_SETTLE: begin
        o.poll = 1'b1; o.poll_on_gate = 1'b1; o.poll_val = 1'b0;
      end
      default: o = '0;
    endcase
    return o;
  endfunction

  function automatic phase_t phase_after(input phase_t ph, input logic full);
    phase_t n;
    case (ph)
      PH_RELEASE_A: n = PH_UNGATE_A;
      PH_UNGATE_A:  n = full ? PH_ENTER : PH_SETTLE;
      PH_ENTER:     n = PH_RELEASE_B;
      PH_RELEASE_B: n = PH_UNGATE_B;
      PH_UNGATE_B:  n = PH_SETTLE;
      default:      n = PH_SETTLE;
    endcase
    return n;
  endfunction

  function automatic seq_state_t entry_state(input phase_t ph);
    phase_op_t o;
    o = phase_op(ph);
    return o.rmw ? ST_RMW_RD : ST_POLL_RD;
  endfunction

endpackage

// File: rtl/rstgate_rmw.sv
module rstgate_rmw #(
  parameter int DATA_W   = 32,
  parameter int SRST_BIT = 31,
  parameter int GATE_BIT = 30
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic              set_val,
  input  logic              on_gate,
  output logic [DATA_W-1:0] wr_word
);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam bit IS_SRST = (i == SRST_BIT);
    localparam bit IS_GATE = (i == GATE_BIT);
    logic picked;
    assign picked     = (on_gate && IS_GATE) || (!on_gate && IS_SRST);
    assign wr_word[i] = picked ? set_val : rd_word[i];
  end

endmodule

// File: rtl/rstgate_poll_timer.sv
module rstgate_poll_timer #(
  parameter int POLL_LIMIT = 1000000,
  localparam int POLL_W = $clog2(POLL_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expired
);

  localparam logic [POLL_W-1:0] LIMIT_V = POLL_W'(POLL_LIMIT);

  logic [POLL_W-1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reads_q <= '0;
    else if (clr)     reads_q <= '0;
    else if (inc && reads_q < LIMIT_V) reads_q <= reads_q + 1'b1;
  end

  assign expired = (reads_q >= LIMIT_V);

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    reads_q <= LIMIT_V); // R5
  AST_NO_READ_PAST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !expired); // R5

endmodule

// File: rtl/rstgate_try_counter.sv
module rstgate_try_counter #(
  parameter int MAX_TRIES = 10,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  output logic [TRY_W-1:0] count,
  output logic             last
);

  localparam logic [TRY_W-1:0] MAX_V = TRY_W'(MAX_TRIES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= TRY_W'(1);
    else if (inc)  count <= count + 1'b1;
  end

  assign last = (count == MAX_V);

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= MAX_V); // R6
  AST_NO_INC_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> !last); // R6

endmodule

// File: rtl/rstgate_seq.sv
module rstgate_seq
  import rstgate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int SRST_BIT   = 31,
  parameter int GATE_BIT   = 30,
  parameter int POLL_LIMIT = 1000000,
  parameter int MAX_TRIES  = 10,
  localparam int TRY_W     = $clog2(MAX_TRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_full,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [TRY_W-1:0]  attempts,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);

  localparam logic [DATA_W-1:0] CTL_MASK =
    (DATA_W'(1) << SRST_BIT) | (DATA_W'(1) << GATE_BIT);

  seq_state_t state_q, state_d;
  phase_t     phase_q, phase_nx;
  logic       full_q;
  logic       done_q, error_q;
  phase_op_t  op;

  // named internal events
  logic ev_accept, ev_rmw_wr, ev_poll_chk, ev_poll_hit, ev_poll_expire;
  logic ev_retry, ev_give_up, ev_finish, ev_advance;
  logic poll_bit, timer_expired, try_last;
  logic timer_clr, timer_inc;

  assign op       = phase_op(phase_q);
  assign phase_nx = phase_after(phase_q, full_q);
  assign poll_bit = op.poll_on_gate ? reg_rdata[GATE_BIT] : reg_rdata[SRST_BIT];

  assign ev_accept      = (state_q == ST_IDLE) && start;
  assign ev_rmw_wr      = (state_q == ST_RMW_WR);
  assign ev_poll_chk    = (state_q == ST_POLL_CHK);
  assign ev_poll_hit    = ev_poll_chk && (poll_bit == op.poll_val);
  assign ev_poll_expire = ev_poll_chk && (poll_bit != op.poll_val) && timer_expired;
  assign ev_give_up     = ev_poll_expire && try_last;
  assign ev_retry       = ev_poll_expire && !try_last;
  assign ev_finish      = ev_poll_hit && (phase_q == PH_SETTLE);
  assign ev_advance     = (ev_rmw_wr && !op.poll) ||
                          (ev_poll_hit && (phase_q != PH_SETTLE));

  assign timer_clr = (state_q == ST_IDLE) || (state_q == ST_RMW_WR);
  assign timer_inc = (state_q == ST_POLL_RD);

  rstgate_poll_timer #(.POLL_LIMIT(POLL_LIMIT)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (timer_clr),
    .inc     (timer_inc),
    .expired (timer_expired)
  );

  rstgate_try_counter #(.MAX_TRIES(MAX_TRIES)) i_tries (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_accept),
    .inc   (ev_retry),
    .count (attempts),
    .last  (try_last)
  );

  rstgate_rmw #(.DATA_W(DATA_W), .SRST_BIT(SRST_BIT), .GATE_BIT(GATE_BIT)) i_rmw (
    .rd_word (reg_rdata),
    .set_val (op.rmw_val),
    .on_gate (op.rmw_on_gate),
    .wr_word (reg_wdata)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (start) state_d = ST_RMW_RD;
      ST_RMW_RD:   state_d = ST_RMW_WR;
      ST_RMW_WR:   state_d = op.poll ? ST_POLL_RD : entry_state(phase_nx);
      ST_POLL_RD:  state_d = ST_POLL_CHK;
      ST_POLL_CHK: begin
        if (ev_finish)        state_d = ST_IDLE;
        else if (ev_poll_hit) state_d = entry_state(phase_nx);
        else if (ev_give_up)  state_d = ST_IDLE;
        else if (ev_retry)    state_d = ST_RMW_RD;
        else                  state_d = ST_POLL_RD;
      end
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_RELEASE_A;
      full_q  <= 1'b0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= ev_finish;
      error_q <= ev_give_up;
      if (ev_accept) full_q <= start_full;
      if (ev_accept || ev_retry) phase_q <= PH_RELEASE_A;
      else if (ev_advance)       phase_q <= phase_nx;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign done   = done_q;
  assign error  = error_q;
  assign reg_rd = (state_q == ST_RMW_RD) || (state_q == ST_POLL_RD);
  assign reg_wr = ev_rmw_wr;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!reg_rd && !reg_wr)); // R1
  AST_NO_RD_WR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R2
  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($countones((reg_wdata ^ reg_rdata) & ~CTL_MASK) == 0 &&
                $countones(reg_wdata ^ reg_rdata) <= 1)); // R2
  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ((reg_wdata & ~CTL_MASK) == (reg_rdata & ~CTL_MASK))); // R10
  AST_DONE_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(reg_rdata[GATE_BIT]) == 1'b0)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERROR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error); // R7
  AST_FINISH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error)); // R7
  AST_FINISH_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !busy); // R7
  AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (attempts == TRY_W'(MAX_TRIES))); // R6
  AST_RETRY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry |=> (attempts == $past(attempts) + 1'b1)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (full_q == $past(full_q))); // R8
  AST_ATTEMPTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(attempts)); // R7

endmodule

// File: tb/test_rstgate_seq.sv
`timescale 1ns/1ps
module test_rstgate_seq;

  localparam int POLL_N = 8;
  localparam int TRY_N  = 3;
  localparam logic [31:0] SRST = 32'h8000_0000;
  localparam logic [31:0] GATE = 32'h4000_0000;
  localparam logic [31:0] INIT = 32'hC5A3_3C96;
  localparam logic [31:0] FIN  = 32'h05A3_3C96;
  localparam logic [9:0]  EN_LOG    = 10'b00_00_00_01_00;
  localparam logic [9:0]  FULL_LOG  = 10'b01_00_10_01_00;
  localparam logic [9:0]  REFUL_LOG = 10'b00_00_10_01_00;

  typedef struct {
    bit          ok;
    int          tries;
    logic [31:0] fin;
    bit          exact;
    int          nw;
    logic [9:0]  wl;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start_full = 1'b0;
  logic busy, done, error;
  logic [1:0] attempts;
  logic reg_rd, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;

  always #2 clk = ~clk;

  rstgate_seq #(.POLL_LIMIT(POLL_N), .MAX_TRIES(TRY_N)) i_rstgate_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_full(start_full),
    .busy(busy), .done(done), .error(error), .attempts(attempts),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // behavioural peripheral register
  logic [31:0] ctrl;
  logic [9:0]  wlog;
  int lag_left, resets_seen;
  logic load = 1'b0;
  logic [31:0] load_val = '0;
  int lag_cfg = 0, fail_cfg = 0;
  bit stuck_cfg = 1'b0;

  always @(posedge clk) begin
    if (load) begin
      ctrl <= load_val; lag_left <= 0; resets_seen <= 0; wlog <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_wdata[31] && !ctrl[31]) begin
          resets_seen <= resets_seen + 1;
          ctrl <= (resets_seen >= fail_cfg) ? (reg_wdata | GATE) : reg_wdata;
        end else begin
          ctrl <= reg_wdata;
        end
        if (!reg_wdata[31] && ctrl[31]) lag_left <= lag_cfg;
        wlog <= {wlog[7:0], reg_wdata[31:30]};
      end
      if (reg_rd) begin
        reg_rdata <= ctrl | ((lag_left > 0) ? SRST : 32'h0) | (stuck_cfg ? GATE : 32'h0);
        if (lag_left > 0) lag_left <= lag_left - 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  exp_t sb_q[$];

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every completion pulse
  initial begin
    exp_t e;
    logic [9:0] m;
    forever begin
      @(negedge clk);
      if (rst_n && (done || error)) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected completion", {30'd0, done, error}, 32'h0);
        end else begin
          e = sb_q.pop_front();
          chk(done == e.ok && error == !e.ok, e.ok ? "R3" : "R6", "outcome done",
              {31'd0, done}, {31'd0, e.ok});
          chk(int'(attempts) == e.tries, "R6", "attempts", 32'(attempts), 32'(e.tries));
          chk(!busy, "R7", "busy in pulse cycle", {31'd0, busy}, 32'h0);
          chk((ctrl & 32'h3FFF_FFFF) == (e.fin & 32'h3FFF_FFFF), "R10", "other bits",
              ctrl, e.fin);
          if (e.exact)
            chk(ctrl == e.fin, "R3", "final control word", ctrl, e.fin);
          if (e.nw > 0) begin
            m = 10'((1 << (2 * e.nw)) - 1);
            chk((wlog & m) == (e.wl & m), e.nw == 5 ? "R4" : "R3", "write history",
                {22'd0, wlog & m}, {22'd0, e.wl & m});
          end
          @(negedge clk);
          chk(!done && !error, "R7", "pulse width", {30'd0, done, error}, 32'h0);
        end
      end
    end
  end

  task automatic push(input bit ok, input int tries, input logic [31:0] fin,
                      input bit exact, input int nw, input logic [9:0] wl);
    exp_t e;
    e.ok = ok; e.tries = tries; e.fin = fin; e.exact = exact; e.nw = nw; e.wl = wl;
    sb_q.push_back(e);
  endtask

  task automatic setup(input logic [31:0] init, input int lag, input int failr,
                       input bit stuck);
    @(negedge clk);
    load_val = init; lag_cfg = lag; fail_cfg = failr; stuck_cfg = stuck; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic kick(input bit full);
    @(negedge clk);
    start = 1'b1; start_full = full;
    @(negedge clk);
    start = 1'b0; start_full = 1'b0;
  endtask

  task automatic drain();
    wait (sb_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error, "R1", "outputs in reset", {29'd0, busy, done, error}, 32'h0);
    chk(!reg_rd && !reg_wr, "R1", "bus quiet in reset", {30'd0, reg_rd, reg_wr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(attempts == 2'd0, "R1", "attempts after reset", 32'(attempts), 32'h0);
    chk(!busy && !reg_rd && !reg_wr, "R1", "idle after reset",
        {29'd0, busy, reg_rd, reg_wr}, 32'h0);

    // R3 enable-only clean, then R7 attempts hold
    setup(INIT, 0, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 2, EN_LOG);
    kick(1'b0);
    drain();
    repeat (5) @(negedge clk);
    chk(attempts == 2'd1, "R7", "attempts held after done", 32'(attempts), 32'h1);

    // R4 full reset clean
    setup(INIT, 0, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 5, FULL_LOG);
    kick(1'b1);
    drain();

    // R4 full reset with release lag below limit
    setup(INIT, 3, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 5, FULL_LOG);
    kick(1'b1);
    drain();

    // R5 match on the last permitted read
    setup(INIT, POLL_N - 1, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 2, EN_LOG);
    kick(1'b0);
    drain();

    // R5 limit reached, R6 retry succeeds on attempt 2
    setup(INIT, POLL_N, 0, 1'b0);
    push(1'b1, 2, FIN, 1'b1, 2, EN_LOG);
    kick(1'b0);
    drain();

    // R6 reset entry ignored once, second attempt succeeds from the first step
    setup(INIT, 0, 1, 1'b0);
    push(1'b1, 2, FIN, 1'b1, 5, REFUL_LOG);
    kick(1'b1);
    drain();

    // R6 reset entry never acknowledged: error after all attempts
    setup(INIT, 0, 5, 1'b0);
    push(1'b0, TRY_N, FIN, 1'b0, 0, '0);
    kick(1'b1);
    drain();

    // R6 clock gate stuck closed in enable-only mode
    setup(INIT, 0, 0, 1'b1);
    push(1'b0, TRY_N, FIN, 1'b0, 0, '0);
    kick(1'b0);
    drain();

    // R8 start with the other mode while busy is ignored
    setup(INIT, 0, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 5, FULL_LOG);
    kick(1'b1);
    repeat (3) @(negedge clk);
    chk(busy, "R8", "busy before second start", {31'd0, busy}, 32'h1);
    start = 1'b1; start_full = 1'b0;
    @(negedge clk);
    start = 1'b0;
    drain();

    // R9 start in the cycle of the done pulse
    setup(INIT, 0, 0, 1'b0);
    push(1'b1, 1, FIN, 1'b1, 2, EN_LOG);
    push(1'b1, 1, FIN, 1'b1, 5, REFUL_LOG);
    kick(1'b0);
    @(negedge clk iff done);
    start = 1'b1; start_full = 1'b1;
    @(negedge clk);
    start = 1'b0; start_full = 1'b0;
    chk(busy, "R9", "new run accepted", {31'd0, busy}, 32'h1);
    drain();

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual busy=%0b expected 0", busy);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule